// File: doc/BRIEF.md
# Address Translation Buffer with Hardware Table Walk

This block turns 32-bit virtual addresses into 30-bit physical addresses for a requester that holds its request steady until it is answered. The low 12 bits (the byte position inside a 4 KB page) pass straight through. The upper 20 bits form the virtual page number. That number is looked up in a small, fully associative buffer of recent translations. Each slot of the buffer holds a valid flag, the virtual page number used as tag, an 18-bit physical page number, a "written" flag and a "recently used" flag.

When the lookup misses, an internal walker reads one 32-bit table entry from memory. It uses a single-level table whose start address is given on the `ptbr` input. If the entry is marked present, the walker installs it in the buffer and the lookup runs again. If the entry is not present, the block reports a page fault and installs nothing. Software-side maintenance is reduced to two pulse inputs. One drops every cached translation. The other clears every use flag, so that recent use can be sampled later.

Top module: `xlate_tlb`

## Requirements
- R1: When a request hits a valid slot whose tag equals bits 31:12 of `req_vaddr`, `resp_ready` is high in the same cycle and `resp_paddr` equals {slot physical page, `req_vaddr[11:0]`}, with `resp_fault` low.
- R2: On a miss, `resp_ready` stays low and the walker raises `mem_rd_valid` with `mem_rd_addr` = `ptbr` + 4 × virtual page number, truncated to 30 bits. The walker holds that address until `mem_rd_ack` is sampled high.
- R3: A table entry with bit 31 set is present, and its bits 17:0 give the physical page. The walker installs it, the retried lookup answers with the translated address, and later accesses to the same page hit with no memory read.
- R4: A table entry with bit 31 clear makes the block assert `resp_fault` together with `resp_ready` for exactly one cycle. Nothing is installed, so the next access to that page walks again.
- R5: A new translation goes into the lowest-numbered invalid slot. When all slots are valid, a rotating pointer picks the victim. The pointer starts at slot 0 after reset and advances by one on each replacement.
- R6: `resp_ref` reports the slot's use flag as it was before the current access. A newly installed slot starts with the flag clear, and every answered hit sets it.
- R7: `resp_dirty` reports the slot's written flag as it was before the current access. A newly installed slot starts with the flag clear, and a hit with `req_write` high sets it.
- R8: A one-cycle pulse on `flush` invalidates every slot, so the next access to any page walks.
- R9: A pulse on `clear_refs` clears every use flag and keeps all translations and written flags.
- R10: After reset all slots are invalid, and with no request pending `resp_ready` and `mem_rd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request, held until answered |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Request is a store |
| resp_ready | output | 1 | Answer present this cycle |
| resp_paddr | output | 30 | Translated physical address |
| resp_fault | output | 1 | Page not present in memory |
| resp_ref | output | 1 | Slot use flag before this access |
| resp_dirty | output | 1 | Slot written flag before this access |
| ptbr | input | 30 | Physical start address of the page table |
| flush | input | 1 | Invalidate all slots |
| clear_refs | input | 1 | Clear all use flags |
| mem_rd_valid | output | 1 | Table-entry read request |
| mem_rd_addr | output | 30 | Byte address of the table entry |
| mem_rd_ack | input | 1 | Read data valid this cycle |
| mem_rd_data | input | 32 | Table entry read from memory |

## Verification
A stale or wrong tag shows up at once as a hit answer with the wrong physical page. A slot that was lost shows up on the next touch of that page as an extra table read and a late `resp_ready`. For that reason the bench counts memory reads per access as well as checking addresses. Status-flag corruption is visible only on the following hit of the same page, through `resp_ref` and `resp_dirty`. A replacement pointer that is off by one shows up only after the buffer has filled, when a page that should still be resident walks again.

// File: rtl/xtlb_pkg.sv
package xtlb_pkg;
    localparam int VA_W   = 32;
    localparam int PA_W   = 30;
    localparam int OFF_W  = 12;
    localparam int VPN_W  = VA_W - OFF_W;
    localparam int PPN_W  = PA_W - OFF_W;
    localparam int PTE_W  = 32;
    localparam int PTE_PRESENT_BIT = 31;

    typedef logic [VPN_W-1:0] vpn_t;
    typedef logic [PPN_W-1:0] ppn_t;
    typedef logic [PA_W-1:0]  paddr_t;

    typedef struct packed {
        logic valid;
        vpn_t tag;
        ppn_t ppn;
        logic dirty;
        logic used;
    } slot_t;

    typedef enum logic [1:0] {
        WK_IDLE  = 2'd0,
        WK_READ  = 2'd1,
        WK_FAULT = 2'd2
    } walk_state_e;

    function automatic paddr_t entry_addr(paddr_t base, vpn_t vpn);
        return base + {{(PA_W-VPN_W-2){1'b0}}, vpn, 2'b00};
    endfunction

    function automatic logic entry_present(logic [PTE_W-1:0] pte);
        return pte[PTE_PRESENT_BIT];
    endfunction

    function automatic ppn_t entry_ppn(logic [PTE_W-1:0] pte);
        return pte[PPN_W-1:0];
    endfunction
endpackage

// File: rtl/xtlb_slots.sv
module xtlb_slots
    import xtlb_pkg::*;
#(
    parameter int N_SLOT = 16,
    localparam int IDX_W = $clog2(N_SLOT)
) (
    input  logic              clk,
    input  logic              rst,
    input  vpn_t              lk_vpn,
    input  logic              lk_take,
    input  logic              lk_write,
    input  logic              flush,
    input  logic              clear_refs,
    input  logic              ins_en,
    input  logic [IDX_W-1:0]  ins_idx,
    input  vpn_t              ins_vpn,
    input  ppn_t              ins_ppn,
    output logic              hit,
    output ppn_t              hit_ppn,
    output logic              hit_used,
    output logic              hit_dirty,
    output logic [N_SLOT-1:0] valid_vec
);
    slot_t             slot [N_SLOT];
    logic [N_SLOT-1:0] match;

    for (genvar g = 0; g < N_SLOT; g++) begin : g_match
        assign match[g]     = slot[g].valid && (slot[g].tag == lk_vpn);
        assign valid_vec[g] = slot[g].valid;
    end

    always_comb begin
        hit       = |match;
        hit_ppn   = '0;
        hit_used  = 1'b0;
        hit_dirty = 1'b0;
        for (int i = 0; i < N_SLOT; i++) begin
            if (match[i]) begin
                hit_ppn   = hit_ppn | slot[i].ppn;
                hit_used  = hit_used | slot[i].used;
                hit_dirty = hit_dirty | slot[i].dirty;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < N_SLOT; i++) begin
            if (rst || flush) begin
                slot[i] <= '0;
            end else if (ins_en && (ins_idx == IDX_W'(i))) begin
                slot[i] <= '{valid: 1'b1, tag: ins_vpn, ppn: ins_ppn, dirty: 1'b0, used: 1'b0};
            end else begin
                if (clear_refs)
                    slot[i].used <= 1'b0;
                if (lk_take && match[i]) begin
                    slot[i].used <= 1'b1;
                    if (lk_write)
                        slot[i].dirty <= 1'b1;
                end
            end
        end
    end

    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match)); // R1
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        flush |=> (valid_vec == '0)); // R8
    AST_INSTALL_FRESH: assert property (@(posedge clk) disable iff (rst)
        (ins_en && !flush) |=> (slot[$past(ins_idx)].valid && !slot[$past(ins_idx)].used)); // R6
endmodule

// File: rtl/xtlb_victim.sv
module xtlb_victim #(
    parameter int N_SLOT = 16,
    localparam int IDX_W = $clog2(N_SLOT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SLOT-1:0] valid_vec,
    input  logic              advance,
    output logic [IDX_W-1:0]  victim
);
    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] free_idx;
    logic             have_free;

    always_comb begin
        have_free = 1'b0;
        free_idx  = '0;
        for (int i = N_SLOT - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                have_free = 1'b1;
                free_idx  = IDX_W'(i);
            end
        end
        victim = have_free ? free_idx : rr_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rr_q <= '0;
        else if (advance && !have_free)
            rr_q <= (rr_q == IDX_W'(N_SLOT - 1)) ? '0 : rr_q + 1'b1;
    end

    AST_VICTIM_FREE_FIRST: assert property (@(posedge clk) disable iff (rst)
        !(&valid_vec) |-> !valid_vec[victim]); // R5
endmodule

// File: rtl/xtlb_walker.sv
module xtlb_walker
    import xtlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             miss,
    input  vpn_t             req_vpn,
    input  paddr_t           ptbr,
    input  logic             mem_rd_ack,
    input  logic [PTE_W-1:0] mem_rd_data,
    output logic             mem_rd_valid,
    output paddr_t           mem_rd_addr,
    output logic             ins_en,
    output vpn_t             ins_vpn,
    output ppn_t             ins_ppn,
    output logic             fault,
    output logic             idle
);
    walk_state_e state_q;
    vpn_t        vpn_q;
    paddr_t      addr_q;
    logic        unused_pte_bits;

    assign unused_pte_bits = ^mem_rd_data[PTE_PRESENT_BIT-1:PPN_W];

    assign idle         = (state_q == WK_IDLE);
    assign fault        = (state_q == WK_FAULT);
    assign mem_rd_valid = (state_q == WK_READ);
    assign mem_rd_addr  = addr_q;
    assign ins_en       = mem_rd_valid && mem_rd_ack && entry_present(mem_rd_data);
    assign ins_vpn      = vpn_q;
    assign ins_ppn      = entry_ppn(mem_rd_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WK_IDLE;
            vpn_q   <= '0;
            addr_q  <= '0;
        end else begin
            unique case (state_q)
                WK_IDLE: if (miss) begin
                    state_q <= WK_READ;
                    vpn_q   <= req_vpn;
                    addr_q  <= entry_addr(ptbr, req_vpn);
                end
                WK_READ: if (mem_rd_ack)
                    state_q <= entry_present(mem_rd_data) ? WK_IDLE : WK_FAULT;
                WK_FAULT: state_q <= WK_IDLE;
                default:  state_q <= WK_IDLE;
            endcase
        end
    end

    AST_READ_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_valid && !mem_rd_ack) |=> (mem_rd_valid && $stable(mem_rd_addr))); // R2
endmodule

// File: rtl/xlate_tlb.sv
module xlate_tlb
    import xtlb_pkg::*;
#(
    parameter int N_SLOT = 16,
    localparam int IDX_W = $clog2(N_SLOT)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic               req_write,
    output logic               resp_ready,
    output logic [PA_W-1:0]    resp_paddr,
    output logic               resp_fault,
    output logic               resp_ref,
    output logic               resp_dirty,
    input  logic [PA_W-1:0]    ptbr,
    input  logic               flush,
    input  logic               clear_refs,
    output logic               mem_rd_valid,
    output logic [PA_W-1:0]    mem_rd_addr,
    input  logic               mem_rd_ack,
    input  logic [PTE_W-1:0]   mem_rd_data
);
    vpn_t              req_vpn;
    logic              hit, hit_used, hit_dirty, walk_idle, take;
    ppn_t              hit_ppn, ins_ppn;
    vpn_t              ins_vpn;
    logic              ins_en, walk_fault;
    logic [IDX_W-1:0]  victim;
    logic [N_SLOT-1:0] valid_vec;

    assign req_vpn = req_vaddr[VA_W-1:OFF_W];
    assign take    = walk_idle && req_valid && hit;

    xtlb_slots #(.N_SLOT(N_SLOT)) u_slots (
        .clk(clk), .rst(rst), .lk_vpn(req_vpn), .lk_take(take), .lk_write(req_write),
        .flush(flush), .clear_refs(clear_refs), .ins_en(ins_en), .ins_idx(victim),
        .ins_vpn(ins_vpn), .ins_ppn(ins_ppn), .hit(hit), .hit_ppn(hit_ppn),
        .hit_used(hit_used), .hit_dirty(hit_dirty), .valid_vec(valid_vec)
    );

    xtlb_victim #(.N_SLOT(N_SLOT)) u_victim (
        .clk(clk), .rst(rst), .valid_vec(valid_vec), .advance(ins_en), .victim(victim)
    );

    xtlb_walker u_walker (
        .clk(clk), .rst(rst), .miss(req_valid && !hit), .req_vpn(req_vpn), .ptbr(ptbr),
        .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data), .mem_rd_valid(mem_rd_valid),
        .mem_rd_addr(mem_rd_addr), .ins_en(ins_en), .ins_vpn(ins_vpn), .ins_ppn(ins_ppn),
        .fault(walk_fault), .idle(walk_idle)
    );

    assign resp_ready = take || walk_fault;
    assign resp_fault = walk_fault;
    assign resp_paddr = {hit_ppn, req_vaddr[OFF_W-1:0]};
    assign resp_ref   = hit_used;
    assign resp_dirty = hit_dirty;

    AST_ABSENT_FAULTS: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_valid && mem_rd_ack && !mem_rd_data[PTE_PRESENT_BIT]) |=> (resp_fault && resp_ready)); // R4
    AST_FAULT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        resp_fault |=> !resp_fault); // R4
    AST_NO_ANSWER_WHILE_READING: assert property (@(posedge clk) disable iff (rst)
        mem_rd_valid |-> !resp_ready); // R2
endmodule

// File: tb/xlate_tlb_tb.sv
module xlate_tlb_tb;
    localparam logic [29:0] BASE = 30'h0100_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        resp_ready, resp_fault, resp_ref, resp_dirty;
    logic [29:0] resp_paddr;
    logic        flush = 1'b0;
    logic        clear_refs = 1'b0;
    logic        mem_rd_valid;
    logic [29:0] mem_rd_addr;
    logic        mem_rd_ack = 1'b0;
    logic [31:0] mem_rd_data = '0;

    int tests = 0;
    int fails = 0;
    int walks = 0;
    int addr_errs = 0;
    logic [19:0] cur_vpn = '0;

    always #4 clk = ~clk;

    xlate_tlb u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr), .req_write(req_write),
        .resp_ready(resp_ready), .resp_paddr(resp_paddr), .resp_fault(resp_fault),
        .resp_ref(resp_ref), .resp_dirty(resp_dirty), .ptbr(BASE), .flush(flush),
        .clear_refs(clear_refs), .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
        .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data)
    );

    function automatic logic page_present(logic [19:0] vpn);
        return vpn[3:0] != 4'hF;
    endfunction

    function automatic logic [17:0] page_frame(logic [19:0] vpn);
        logic [31:0] t;
        t = {12'd0, vpn} * 32'd13 + 32'd5;
        return t[17:0];
    endfunction

    function automatic logic [31:0] table_word(logic [29:0] addr);
        logic [29:0] off;
        logic [19:0] vpn;
        off = addr - BASE;
        vpn = off[21:2];
        return {page_present(vpn), 13'h1ABC, page_frame(vpn)};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // memory responder: random latency 0..3 cycles
    initial begin
        int lat;
        lat = 1;
        forever begin
            @(negedge clk);
            if (mem_rd_ack) begin
                mem_rd_ack = 1'b0;
            end else if (mem_rd_valid) begin
                if (lat == 0) begin
                    mem_rd_ack  = 1'b1;
                    mem_rd_data = table_word(mem_rd_addr);
                    walks++;
                    if (mem_rd_addr != BASE + {8'd0, cur_vpn, 2'b00}) addr_errs++;
                    lat = int'($urandom % 4);
                end else begin
                    lat--;
                end
            end
        end
    end

    task automatic access(input logic [31:0] va, input bit wr,
                          output logic [29:0] pa, output bit flt, output bit rf, output bit dt,
                          output int cyc, output int nwalk);
        int w0;
        w0 = walks;
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = va;
        req_write = wr;
        cur_vpn   = va[31:12];
        cyc = 0;
        #1;
        while (!resp_ready && cyc < 100) begin
            @(negedge clk);
            #1;
            cyc++;
        end
        pa = resp_paddr;
        flt = resp_fault;
        rf = resp_ref;
        dt = resp_dirty;
        nwalk = walks - w0;
        if (cyc >= 100) check(1'b0, "R2 (no answer)", 32'(cyc), 32'd0);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    task automatic pulse_flush();
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
    endtask

    task automatic pulse_clear();
        @(negedge clk); clear_refs = 1'b1;
        @(negedge clk); clear_refs = 1'b0;
    endtask

    function automatic logic [29:0] xlat(logic [31:0] va);
        return {page_frame(va[31:12]), va[11:0]};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 32'd0, 32'd1);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [29:0] pa;
        bit flt, rf, dt;
        int cyc, nw;
        int seed;
        logic [31:0] va;
        logic [19:0] vp [17];

        seed = int'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(resp_ready == 1'b0, "R10 ready after reset", 32'(resp_ready), 32'd0);
        check(mem_rd_valid == 1'b0, "R10 no read after reset", 32'(mem_rd_valid), 32'd0);

        // first touch walks, installs, retries
        va = 32'h1234_5678;
        access(va, 1'b0, pa, flt, rf, dt, cyc, nw);
        check(nw == 1 && cyc > 0, "R2 miss walks once", 32'(nw), 32'd1);
        check(addr_errs == 0, "R2 table address", 32'(addr_errs), 32'd0);
        check(pa == xlat(va) && !flt, "R3 installed translation", 32'(pa), 32'(xlat(va)));
        check(rf == 1'b0 && dt == 1'b0, "R6 R7 fresh slot flags", {30'd0, rf, dt}, 32'd0);

        va = 32'h1234_5ABC;
        access(va, 1'b0, pa, flt, rf, dt, cyc, nw);
        check(cyc == 0 && nw == 0, "R1 R3 same-cycle hit", 32'(cyc), 32'd0);
        check(pa == xlat(va), "R1 hit address", 32'(pa), 32'(xlat(va)));
        check(rf == 1'b1, "R6 use flag set by hit", 32'(rf), 32'd1);

        access(va, 1'b1, pa, flt, rf, dt, cyc, nw);
        check(dt == 1'b0, "R7 dirty before first write", 32'(dt), 32'd0);
        access(va, 1'b0, pa, flt, rf, dt, cyc, nw);
        check(dt == 1'b1, "R7 dirty after write", 32'(dt), 32'd1);

        pulse_clear();
        access(va, 1'b0, pa, flt, rf, dt, cyc, nw);
        check(rf == 1'b0, "R9 use flag cleared", 32'(rf), 32'd0);
        check(dt == 1'b1 && nw == 0 && pa == xlat(va), "R9 translation and dirty kept", {30'd0, dt, 1'b0}, 32'd2);

        // absent page
        va = 32'h0000_F010;
        access(va, 1'b0, pa, flt, rf, dt, cyc, nw);
        check(flt == 1'b1 && nw == 1, "R4 fault on absent entry", 32'(flt), 32'd1);
        @(negedge clk);
        check(resp_fault == 1'b0, "R4 fault lasts one cycle", 32'(resp_fault), 32'd0);
        access(va, 1'b1, pa, flt, rf, dt, cyc, nw);
        check(flt == 1'b1 && nw == 1, "R4 nothing installed", 32'(nw), 32'd1);

        // flush
        pulse_flush();
        va = 32'h1234_5000;
        access(va, 1'b0, pa, flt, rf, dt, cyc, nw);
        check(nw == 1 && pa == xlat(va), "R8 flush forces walk", 32'(nw), 32'd1);

        // replacement order
        pulse_flush();
        for (int k = 0; k < 17; k++) vp[k] = 20'h00200 + 20'(k * 16);
        for (int k = 0; k < 16; k++) begin
            access({vp[k], 12'h004}, 1'b0, pa, flt, rf, dt, cyc, nw);
            check(nw == 1, "R5 fill walk", 32'(nw), 32'd1);
        end
        for (int k = 0; k < 16; k++) begin
            access({vp[k], 12'h008}, 1'b0, pa, flt, rf, dt, cyc, nw);
            check(nw == 0 && pa == {page_frame(vp[k]), 12'h008}, "R5 free slots used first", 32'(nw), 32'd0);
        end
        access({vp[16], 12'h0}, 1'b0, pa, flt, rf, dt, cyc, nw);
        check(nw == 1, "R5 new page walks", 32'(nw), 32'd1);
        access({vp[1], 12'h0}, 1'b0, pa, flt, rf, dt, cyc, nw);
        check(nw == 0, "R5 slot 1 kept", 32'(nw), 32'd0);
        access({vp[0], 12'h0}, 1'b0, pa, flt, rf, dt, cyc, nw);
        check(nw == 1, "R5 slot 0 was victim", 32'(nw), 32'd1);
        access({vp[1], 12'h0}, 1'b0, pa, flt, rf, dt, cyc, nw);
        check(nw == 1, "R5 pointer advanced to slot 1", 32'(nw), 32'd1);
        access({vp[3], 12'h0}, 1'b0, pa, flt, rf, dt, cyc, nw);
        check(nw == 0, "R5 slot 3 kept", 32'(nw), 32'd0);

        // random mix
        for (int n = 0; n < 400; n++) begin
            if (($urandom % 50) == 0) pulse_flush();
            va = {20'h03000 + 20'($urandom % 40), 12'($urandom)};
            access(va, 1'($urandom), pa, flt, rf, dt, cyc, nw);
            if (page_present(va[31:12]))
                check(!flt && pa == xlat(va), "R1 R3 random translation", 32'(pa), 32'(xlat(va)));
            else
                check(flt, "R4 random fault", 32'(flt), 32'd1);
        end
        check(addr_errs == 0, "R2 all table addresses", 32'(addr_errs), 32'd0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule